// File: doc/BRIEF.md
# Double-Data-Rate Strobe Data Path for a Flash Bus

This block carries the data phase of a synchronous, double-data-rate flash transfer on a byte-wide bus. It runs on a fast clock at four times the flash clock, which lets it place every strobe edge to within one fast cycle. It generates the flash clock itself by dividing the fast clock by four. A host asks for a burst with a one-cycle `start` pulse, a direction and an even byte count. The block then drives the direction line, waits out a setup interval and starts the data phase on a rising edge of the flash clock. In the data phase it moves one byte every half flash-clock period.

For a write, the block takes bytes from the host one at a time through a pop strobe. It holds each byte on the bus for two fast cycles. It toggles the outgoing strobe in the second cycle of each byte, so every strobe edge falls in the middle of the data eye. For a read, the flash drives the strobe with edges aligned to the data transitions. The block detects each incoming strobe transition and samples the bus one fast cycle later, at the centre of the byte. It places the byte in a small first-word-fall-through FIFO, which the host drains.

Top module: `ddr_strobe_xfer`

## Requirements
- R1: `f_clk` is the fast clock divided by four. It is 1 from reset for the first two fast cycles of each period and 0 for the next two.
- R2: An accepted `start` sets `f_wr_rd_n` to `wr_mode` (1 = write, 0 = read) one cycle later. The line keeps that value for the whole burst and after it. Its reset value is 1.
- R3: The first data cycle of a burst begins at the first rising edge of `f_clk` that comes at least TCALS fast cycles after the edge that accepted `start`.
- R4: In a write burst of N bytes, `wr_pop` is high in the cycle before each byte is needed. The byte on `wr_byte` in that cycle appears on `f_dq_out` for exactly two fast cycles, in pop order. `f_dq_oe` is high for exactly 2N cycles.
- R5: In a write burst, `f_dqs_oe` is high during the 2N data cycles. `f_dqs_out` rises in the second cycle of every even-numbered byte and falls in the second cycle of every odd-numbered byte, counting from byte 0. It is low outside the burst.
- R6: In a read burst, `f_dq_oe` and `f_dqs_oe` stay low. Each transition of `f_dqs_in` that is seen during the data phase causes `f_dq_in` to be sampled one fast cycle later and pushed into the FIFO. Transitions seen outside a read data phase have no effect.
- R7: A write burst ends after 2N data cycles. A read burst ends on the edge that samples its Nth byte. `busy` is high from the cycle after an accepted `start` until the burst ends.
- R8: `start` is ignored while `busy` is high, and also when `burst_len` is zero or odd (bit 0 set).
- R9: `rd_valid` is high while the FIFO holds data, and `rd_data` shows the oldest byte. `rd_pop` removes that byte and is ignored when the FIFO is empty. A byte sampled while the FIFO is full is dropped.
- R10: After reset, `busy`, `wr_pop`, `f_dq_oe`, `f_dqs_oe`, `f_dqs_out` and `rd_valid` are 0, and `f_clk` and `f_wr_rd_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the flash clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst request pulse |
| wr_mode | input | 1 | Direction of the requested burst, 1 = write |
| burst_len | input | LEN_W | Burst length in bytes, even and non-zero |
| wr_byte | input | DW | Next write byte from the host |
| wr_pop | output | 1 | The host's current write byte is taken this cycle |
| busy | output | 1 | A burst is in progress |
| rd_valid | output | 1 | The read FIFO holds at least one byte |
| rd_data | output | DW | Oldest byte in the read FIFO |
| rd_pop | input | 1 | Remove the oldest read byte |
| f_clk | output | 1 | Flash clock |
| f_wr_rd_n | output | 1 | Transfer direction to the flash |
| f_dq_out | output | DW | Write data to the bus |
| f_dq_oe | output | 1 | Drive enable for the data bus |
| f_dq_in | input | DW | Read data from the bus |
| f_dqs_out | output | 1 | Write strobe to the flash |
| f_dqs_oe | output | 1 | Drive enable for the strobe |
| f_dqs_in | input | 1 | Read strobe from the flash |

## Verification
The bench builds the block with TCALS=3, FIFO_DEPTH=4 and LEN_W=6. The short setup lets bursts start at each of the four flash-clock phases, so the alignment wait takes every length from three to six cycles. The four-entry FIFO lets a six-byte read with no draining overflow and drop its last two bytes. Write bursts of two, six and eight bytes cover strobe patterns that end after an even and an odd number of full strobe periods. Stray read strobes while idle and stray `start` pulses during a burst are checked to have no effect.

// File: rtl/ddr_xfer_pkg.sv
package ddr_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/ddr_clk_phase.sv
module ddr_clk_phase (
  input  logic       clk,
  input  logic       rst,
  output logic [1:0] ph,
  output logic       f_clk
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= 2'd0;
      f_clk <= 1'b1;
    end else begin
      ph    <= ph + 2'd1;
      f_clk <= (ph == 2'd3) || (ph == 2'd0);
    end
  end

  // R1
  fclk_period_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(f_clk) |-> !$past(f_clk, 2));
  // R1
  fclk_high_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(f_clk) |-> $past(f_clk, 2));
endmodule

// File: rtl/ddr_rd_capture.sv
module ddr_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          dqs_in,
  input  logic [DW-1:0] dq_in,
  output logic          push,
  output logic [DW-1:0] push_data
);
  logic dqs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      dqs_prev <= 1'b0;
      push     <= 1'b0;
    end else begin
      dqs_prev <= dqs_in;
      push     <= active && (dqs_in != dqs_prev);
    end
  end

  // sampled one fast cycle after the strobe transition, mid-eye
  assign push_data = dq_in;

  // R6
  push_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> ($past(dqs_in) != $past(dqs_in, 2)));
endmodule

// File: rtl/ddr_byte_fifo.sv
module ddr_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          valid,
  output logic [DW-1:0] data
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          full, empty, do_wr, do_rd;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    end
  end

  assign valid = !empty;
  assign data  = mem[rptr];

  // R9
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  // R9
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/ddr_strobe_xfer.sv
module ddr_strobe_xfer
  import ddr_xfer_pkg::*;
#(
  parameter int DW         = 8,
  parameter int LEN_W      = 8,
  parameter int TCALS      = 4,
  parameter int FIFO_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wr_mode,
  input  logic [LEN_W-1:0] burst_len,
  input  logic [DW-1:0]    wr_byte,
  output logic             wr_pop,
  output logic             busy,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  input  logic             rd_pop,
  output logic             f_clk,
  output logic             f_wr_rd_n,
  output logic [DW-1:0]    f_dq_out,
  output logic             f_dq_oe,
  input  logic [DW-1:0]    f_dq_in,
  output logic             f_dqs_out,
  output logic             f_dqs_oe,
  input  logic             f_dqs_in
);
  localparam int CW = LEN_W + 1;
  localparam int SW = $clog2(TCALS) + 1;

  xfer_state_e      state;
  logic             mode_wr;
  logic [LEN_W-1:0] len_q, rcnt;
  logic [CW-1:0]    cnt, next_cnt, last_c;
  logic [SW-1:0]    setcnt;
  logic [1:0]       ph;
  logic             len_ok, setup_done, enter, wr_more, wr_next;
  logic             rd_active, push;
  logic [DW-1:0]    push_data;

  ddr_clk_phase u_phase (.clk(clk), .rst(rst), .ph(ph), .f_clk(f_clk));

  assign len_ok     = (burst_len != '0) && !burst_len[0];
  assign setup_done = (setcnt >= SW'(TCALS - 1));
  assign enter      = (state == ST_SETUP) && setup_done && (ph == 2'd3);
  assign last_c     = {len_q, 1'b0} - CW'(1);
  assign wr_more    = (state == ST_XFER) && mode_wr && (cnt != last_c);
  assign wr_next    = (enter && mode_wr) || wr_more;
  assign next_cnt   = enter ? '0 : cnt + CW'(1);
  assign wr_pop     = wr_next && !next_cnt[0];
  assign rd_active  = (state == ST_XFER) && !mode_wr;
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_wr   <= 1'b1;
      len_q     <= '0;
      cnt       <= '0;
      rcnt      <= '0;
      setcnt    <= '0;
      f_wr_rd_n <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start && len_ok) begin
          state     <= ST_SETUP;
          mode_wr   <= wr_mode;
          len_q     <= burst_len;
          setcnt    <= '0;
          f_wr_rd_n <= wr_mode;
        end
        ST_SETUP: if (enter) begin
          state <= ST_XFER;
          cnt   <= '0;
          rcnt  <= '0;
        end else if (!setup_done) begin
          setcnt <= setcnt + SW'(1);
        end
        ST_XFER: if (mode_wr) begin
          cnt <= next_cnt;
          if (cnt == last_c) state <= ST_IDLE;
        end else if (push) begin
          rcnt <= rcnt + LEN_W'(1);
          if (rcnt == len_q - LEN_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // write-side outputs: byte changes on even cycle, strobe toggles on odd
  always_ff @(posedge clk) begin
    if (rst) begin
      f_dq_oe   <= 1'b0;
      f_dqs_oe  <= 1'b0;
      f_dqs_out <= 1'b0;
      f_dq_out  <= '0;
    end else begin
      f_dq_oe   <= wr_next;
      f_dqs_oe  <= wr_next;
      f_dqs_out <= wr_next && (next_cnt[1] ^ next_cnt[0]);
      if (wr_pop) f_dq_out <= wr_byte;
    end
  end

  ddr_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .active(rd_active), .dqs_in(f_dqs_in),
    .dq_in(f_dq_in), .push(push), .push_data(push_data)
  );

  ddr_byte_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .pop(rd_pop), .valid(rd_valid), .data(rd_data)
  );

  // R3
  first_byte_align_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(f_dq_oe) |-> (f_clk && !$past(f_clk)));
  // R5
  dqs_mid_eye_chk: assert property (@(posedge clk) disable iff (rst)
    (f_dqs_out != $past(f_dqs_out)) |-> (f_dq_out == $past(f_dq_out)));
  // R6
  read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !f_wr_rd_n |-> (!f_dq_oe && !f_dqs_oe));
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(f_wr_rd_n));
  // R5
  dqs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !f_dqs_oe |-> !f_dqs_out);
endmodule

// File: tb/ddr_strobe_xfer_test.sv
module ddr_strobe_xfer_test;
  localparam int DW = 8, LEN_W = 6, TCALS = 3, DEPTH = 4, FD = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, wr_mode = 1'b1, rd_pop = 1'b0;
  logic [LEN_W-1:0] burst_len = '0;
  logic [DW-1:0] wr_byte = '0, f_dq_in = '0;
  logic f_dqs_in = 1'b0;
  logic wr_pop, busy, rd_valid, f_clk, f_wr_rd_n, f_dq_oe, f_dqs_out, f_dqs_oe;
  logic [DW-1:0] rd_data, f_dq_out;

  always #4 clk = ~clk;

  ddr_strobe_xfer #(.DW(DW), .LEN_W(LEN_W), .TCALS(TCALS), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .start(start), .wr_mode(wr_mode), .burst_len(burst_len),
    .wr_byte(wr_byte), .wr_pop(wr_pop), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_pop(rd_pop), .f_clk(f_clk), .f_wr_rd_n(f_wr_rd_n),
    .f_dq_out(f_dq_out), .f_dq_oe(f_dq_oe), .f_dq_in(f_dq_in),
    .f_dqs_out(f_dqs_out), .f_dqs_oe(f_dqs_oe), .f_dqs_in(f_dqs_in)
  );

  integer checks = 0, errors = 0, cyc = 0;
  bit armed = 0, done = 0, m_inrst = 0;

  // behavioural reference
  integer m_ph = 0, st = 0, m_k = 0, m_c = 0, m_len = 0, m_got = 0, widx = 0;
  bit m_wr = 1, m_wrn = 1, m_prev = 0, m_edge_d = 0, m_rstart = 0;
  logic [7:0] m_dq = 0;
  logic [7:0] q[$];
  logic [7:0] wsrc[64];
  logic [7:0] rsrc[64];
  integer rbase = 0;

  // flash-side driver
  bit fl_active = 0, fl_phase = 0;
  integer fl_wait = 0, fl_i = 0, fl_n = 0, wiggle_n = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    integer so, pre;
    bit nedge;
    if (rst) begin
      m_ph = 0; st = 0; m_wrn = 1; m_prev = 0; m_edge_d = 0; m_k = 0; m_c = 0;
      q.delete(); m_inrst = 1;
    end else begin
      m_inrst = 0;
      so = st;
      m_ph = (m_ph + 1) % 4;
      pre = q.size();
      if (rd_pop && pre > 0) void'(q.pop_front());
      if (m_edge_d && pre < DEPTH) q.push_back(f_dq_in);
      nedge = (so == 2) && !m_wr && (f_dqs_in != m_prev);
      m_prev = f_dqs_in;
      case (so)
        0: if (start && burst_len != 0 && burst_len % 2 == 0) begin
             st = 1; m_k = 0; m_len = burst_len; m_wr = wr_mode; m_wrn = wr_mode;
           end
        1: begin
             m_k++;
             if (m_k >= TCALS && m_ph == 0) begin
               st = 2; m_c = 0; m_got = 0;
               if (!m_wr) m_rstart = 1;
             end
           end
        2: if (m_wr) begin
             m_c++;
             if (m_c == 2 * m_len) st = 0;
           end else if (m_edge_d) begin
             m_got++;
             if (m_got == m_len) st = 0;
           end
        default: st = 0;
      endcase
      m_edge_d = nedge;
      if (st == 2 && m_wr && m_c % 2 == 0) begin
        m_dq = wsrc[widx % 64];
        widx++;
      end
    end
  end

  // write byte source, flash read driver
  always @(negedge clk) begin
    wr_byte <= wsrc[widx % 64];
    if (m_rstart) begin
      m_rstart = 0; fl_active = 1; fl_wait = FD; fl_i = 0; fl_phase = 0; fl_n = m_len;
    end
    if (fl_active) begin
      if (fl_wait > 0) fl_wait--;
      else if (!fl_phase) begin
        if (fl_i < fl_n) begin
          f_dq_in <= rsrc[(rbase + fl_i) % 64];
          f_dqs_in <= ~f_dqs_in;
          fl_i++;
          fl_phase = 1;
        end else begin
          fl_active = 0;
          rbase = rbase + fl_n;
        end
      end else fl_phase = 0;
    end else if (wiggle_n > 0) begin
      f_dq_in <= 8'hEE;
      f_dqs_in <= ~f_dqs_in;
      wiggle_n--;
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    bit e_wact, e_pop;
    if (armed && !done) begin
      e_wact = (st == 2) && m_wr;
      e_pop = (st == 1 && m_k + 1 >= TCALS && m_ph == 3 && m_wr) ||
              (e_wact && (m_c + 1 < 2 * m_len) && ((m_c + 1) % 2 == 0));
      if (m_inrst) begin
        chk("R10 busy", 32'(busy), 0);
        chk("R10 dq_oe", 32'(f_dq_oe), 0);
        chk("R10 dqs_oe", 32'(f_dqs_oe), 0);
        chk("R10 dqs", 32'(f_dqs_out), 0);
        chk("R10 rd_valid", 32'(rd_valid), 0);
        chk("R10 wr_pop", 32'(wr_pop), 0);
        chk("R10 fclk", 32'(f_clk), 1);
        chk("R10 wrn", 32'(f_wr_rd_n), 1);
      end else begin
        chk("R1 fclk", 32'(f_clk), 32'(m_ph < 2));
        chk("R2 wr_rd_n", 32'(f_wr_rd_n), 32'(m_wrn));
        chk("R3/R4 dq_oe", 32'(f_dq_oe), 32'(e_wact));
        chk("R5/R6 dqs_oe", 32'(f_dqs_oe), 32'(e_wact));
        chk("R5 dqs", 32'(f_dqs_out), 32'(e_wact && (m_c % 4 == 1 || m_c % 4 == 2)));
        chk("R4 wr_pop", 32'(wr_pop), 32'(e_pop));
        if (e_wact) chk("R4 dq_out", 32'(f_dq_out), 32'(m_dq));
        chk("R7/R8 busy", 32'(busy), 32'(st != 0));
        chk("R9 rd_valid", 32'(rd_valid), 32'(q.size() > 0));
        if (q.size() > 0) chk("R6/R9 rd_data", 32'(rd_data), 32'(q[0]));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic burst(input bit wm, input integer n, input integer gap, input bit poke);
    repeat (gap) @(negedge clk);
    start <= 1'b1; wr_mode <= wm; burst_len <= LEN_W'(n);
    @(negedge clk);
    start <= 1'b0;
    if (poke) begin
      // R8: stray request during a burst must be ignored
      repeat (5) @(negedge clk);
      start <= 1'b1; wr_mode <= ~wm; burst_len <= LEN_W'(2);
      @(negedge clk);
      start <= 1'b0;
    end
    while (st != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      wsrc[i] = 8'(8'h31 + i * 13);
      rsrc[i] = 8'(8'hA5 ^ (i * 29));
    end
    armed = 1;
    repeat (3) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    burst(1, 4, 0, 0);         // R4 R5 write, minimal gap
    burst(1, 6, 1, 0);         // odd number of byte pairs
    burst(1, 2, 2, 0);
    burst(1, 8, 3, 1);         // R8 poke while busy
    rd_pop <= 1'b1;
    burst(0, 4, 0, 0);         // R6 read with draining
    burst(0, 2, 1, 1);
    burst(0, 3, 0, 0);         // R8 odd length ignored
    burst(0, 0, 0, 0);         // R8 zero length ignored
    wiggle_n = 6;              // R6 idle strobe ignored
    repeat (16) @(negedge clk);
    rd_pop <= 1'b0;
    burst(0, 6, 2, 0);         // R9 overflow drops
    repeat (4) @(negedge clk);
    rd_pop <= 1'b1;
    repeat (8) @(negedge clk); // R9 pop past empty
    burst(1, 6, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule